// File: doc/BRIEF.md
# Shared-Line Bus Hand-Off Arbiter

This block sits beside the bus-cycle sequencer of a bus owner and hands the bus to external masters through single-wire request/grant lines. Each line is active low and carries all three steps of an exchange as one-clock low pulses. The external master pulls the line low once to ask for the bus. The block answers with a one-clock low grant pulse on the same line, floats its bus, and waits. The master then pulls the line low once more to give the bus back. Each line is modelled as three signals: an input sample, an output value and an output enable.

The block reads the owner's bus-cycle phase and three qualifiers: a locked-instruction flag, a flag for the first half of a split odd-address word, and a flag for the first cycle of an interrupt-acknowledge pair. From these it decides the earliest clock at which it may give the bus away. When the bus is idle it grants at once. During a running cycle it grants only after a T4 at which every qualifier allows it. Line 0 wins over line 1 when both ask together. Each exchange ends with one dead clock during which no new request is accepted.

Top module: `bus_yield_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, no line is enabled and `bus_floated` is low. Line lows during reset start no exchange.
- R2: A grant is a single clock with `rg_oe` high and `rg_out` low on exactly one line, the line that requested. It appears in the clock after a qualifying idle or T4 clock.
- R3: The phase input is encoded as IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5. A request seen in an IDLE clock is granted in the very next clock.
- R4: `bus_floated` is high from the clock after the grant until the clock in which the release pulse is seen, inclusive. During that time `holder` gives the index of the granted line.
- R5: A low on the holding line while floated makes `bus_floated` drop in the next clock, and the bus is taken back.
- R6: The clock after the bus is taken back is dead, and a request seen in it is ignored. A request seen in the clock after the dead clock is accepted.
- R7: When both lines are low in the same accepting clock, line 0 is granted.
- R8: A request first seen in T1, T2 or T4 may be granted after the next T4. A request first seen in T3 or TW must wait for the T4 of the following bus cycle. A pending request is granted after any IDLE clock.
- R9: No grant follows a T4 in which the lock, split-first or interrupt-acknowledge-first flag is high. The request stays pending and is retried at later T4 clocks.
- R10: Once a line's request has been accepted, lows on the other line are ignored until the exchange and its dead clock are over.
- R11: A low on the pending line while its request is waiting for a grant is treated as noise. It changes neither the timing nor the line of the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rg_in | input | NUM_LINES | Sampled level of each request/grant line, active low |
| rg_out | output | NUM_LINES | Value driven onto each line while enabled (low) |
| rg_oe | output | NUM_LINES | Output enable per line, high only during a grant pulse |
| phase | input | 3 | Current bus-cycle phase of the owner (encoding in R3) |
| lock_active | input | 1 | A locked instruction is in progress |
| split_first | input | 1 | Current cycle is the first half of an odd-address word split |
| inta_first | input | 1 | Current cycle is the first of the interrupt-acknowledge pair |
| bus_floated | output | 1 | Bus released to an external master |
| holder | output | LINE_W | Index of the line holding the bus, valid while floated |

## Verification
The assertions assume that the external masters drive the lines synchronously and that the phase input only takes the six encoded values. They also assume that a master releases only the line it was granted on. A grant therefore always traces back to an IDLE or T4 clock, and `holder` names a line whose release can end the float. The stimulus drives every input at the falling edge. It walks the phase through whole T1..T4 cycles, with TW in some of them, or holds it at IDLE, and it places each release pulse only on the line that holds the bus. A behavioural model in the bench predicts the output lines, the float flag and the holder on every clock, including the noise pulses, the dead clock and the blocked T4 clocks.

// File: rtl/rg_pkg.sv
// Package: shared types for the request/grant hand-off arbiter.
// Assumes phase values outside the enumerated set never occur.
package rg_pkg;

    // Bus-cycle phase reported by the owner's sequencer.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_e;

    // Exchange sequencer states.
    typedef enum logic [2:0] {
        XS_OWN   = 3'd0,
        XS_WAIT  = 3'd1,
        XS_GRANT = 3'd2,
        XS_HOLD  = 3'd3,
        XS_DEAD  = 3'd4
    } xchg_state_e;

endpackage

// File: rtl/rg_line_pads.sv
// Module: per-line pad split. Turns each active-low line sample into a
// "low seen" flag and drives the grant pulse onto the selected line only.
// Assumes the line inputs are already synchronous to clk.
module rg_line_pads #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input  logic [NUM_LINES-1:0] rg_in,
    input  logic                 grant_fire,
    input  logic [LINE_W-1:0]    grant_line,
    output logic [NUM_LINES-1:0] low_seen,
    output logic [NUM_LINES-1:0] rg_out,
    output logic [NUM_LINES-1:0] rg_oe
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Active-low decode of the shared wire.
        assign low_seen[g] = ~rg_in[g];
        // Enable only the granted line, and only in the grant clock.
        assign rg_oe[g]    = grant_fire && (grant_line == LINE_W'(g));
        // Pull the line low whenever it is enabled.
        assign rg_out[g]   = ~rg_oe[g];
    end

endmodule

// File: rtl/rg_req_pick.sv
// Module: fixed-priority picker. The lowest-numbered low line wins.
// Assumes at most one grant is in progress (the sequencer enforces this).
module rg_req_pick #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input  logic [NUM_LINES-1:0] low_seen,
    output logic                 req_any,
    output logic [LINE_W-1:0]    req_line
);

    // Scan from high index down so that the lowest index overwrites last.
    always_comb begin
        req_any  = |low_seen;
        req_line = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (low_seen[i]) begin
                req_line = LINE_W'(i);
            end
        end
    end

endmodule

// File: rtl/rg_yield_gate.sv
// Module: decodes the bus phase and the release qualifiers into the
// three decisions the sequencer needs: idle bus, late arrival phase,
// and a T4 at which the bus may be given away.
// Assumes qualifier flags are valid in the same clock as the phase.
module rg_yield_gate (
    input  rg_pkg::bus_phase_e phase,
    input  logic               lock_active,
    input  logic               split_first,
    input  logic               inta_first,
    output logic               idle_now,
    output logic               late_now,
    output logic               t4_now,
    output logic               t4_clear
);
    import rg_pkg::*;

    // Phase decode and the all-clear test at T4.
    always_comb begin
        idle_now = (phase == PH_IDLE);
        late_now = (phase == PH_T3) || (phase == PH_TW);
        t4_now   = (phase == PH_T4);
        t4_clear = t4_now && !lock_active && !split_first && !inta_first;
    end

endmodule

// File: rtl/rg_exchange_fsm.sv
// Module: exchange sequencer. Accepts one request, waits for a legal
// hand-off point, issues the grant, holds floated until the release
// pulse on the same line, then spends one dead clock.
// Assumes pulses are one clock wide and synchronous.
module rg_exchange_fsm #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_any,
    input  logic [LINE_W-1:0]    req_line,
    input  logic [NUM_LINES-1:0] low_seen,
    input  logic                 idle_now,
    input  logic                 late_now,
    input  logic                 t4_now,
    input  logic                 t4_clear,
    output logic                 grant_fire,
    output logic                 floated,
    output logic [LINE_W-1:0]    line_q
);
    import rg_pkg::*;

    xchg_state_e state_q, state_d;
    logic [LINE_W-1:0] line_d;
    logic early_q, early_d;
    logic rel_seen;

    // Release is a low on the line that holds the bus.
    assign rel_seen = low_seen[line_q];

    // Next-state decision for one exchange.
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        early_d = early_q;
        unique case (state_q)
            XS_OWN: begin
                if (req_any) begin
                    line_d = req_line;
                    if (idle_now) begin
                        state_d = XS_GRANT;
                    end else begin
                        state_d = XS_WAIT;
                        early_d = !late_now;
                    end
                end
            end
            XS_WAIT: begin
                if (idle_now) begin
                    state_d = XS_GRANT;
                end else if (t4_now) begin
                    if (early_q && t4_clear) begin
                        state_d = XS_GRANT;
                    end else begin
                        early_d = 1'b1;
                    end
                end
            end
            XS_GRANT: state_d = XS_HOLD;
            XS_HOLD: begin
                if (rel_seen) begin
                    state_d = XS_DEAD;
                end
            end
            XS_DEAD:  state_d = XS_OWN;
            default:  state_d = XS_OWN;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_OWN;
            line_q  <= '0;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            early_q <= early_d;
        end
    end

    assign grant_fire = (state_q == XS_GRANT);
    assign floated    = (state_q == XS_HOLD);

endmodule

// File: rtl/bus_yield_arbiter.sv
// Module: top of the request/grant hand-off arbiter.
// Wires the pad split, the priority picker, the phase gate and the
// exchange sequencer. Assumes synchronous line inputs and a phase
// input restricted to the six encoded values.
module bus_yield_arbiter #(
    parameter int NUM_LINES = 2,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rg_in,
    output logic [NUM_LINES-1:0] rg_out,
    output logic [NUM_LINES-1:0] rg_oe,
    input  logic [2:0]           phase,
    input  logic                 lock_active,
    input  logic                 split_first,
    input  logic                 inta_first,
    output logic                 bus_floated,
    output logic [LINE_W-1:0]    holder
);
    import rg_pkg::*;

    logic [NUM_LINES-1:0] low_seen;
    logic                 req_any;
    logic [LINE_W-1:0]    req_line;
    logic                 idle_now, late_now, t4_now, t4_clear;
    logic                 grant_fire;
    logic [LINE_W-1:0]    line_q;

    rg_line_pads #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pads (
        .rg_in      (rg_in),
        .grant_fire (grant_fire),
        .grant_line (line_q),
        .low_seen   (low_seen),
        .rg_out     (rg_out),
        .rg_oe      (rg_oe)
    );

    rg_req_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pick (
        .low_seen (low_seen),
        .req_any  (req_any),
        .req_line (req_line)
    );

    rg_yield_gate u_gate (
        .phase       (bus_phase_e'(phase)),
        .lock_active (lock_active),
        .split_first (split_first),
        .inta_first  (inta_first),
        .idle_now    (idle_now),
        .late_now    (late_now),
        .t4_now      (t4_now),
        .t4_clear    (t4_clear)
    );

    rg_exchange_fsm #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_any    (req_any),
        .req_line   (req_line),
        .low_seen   (low_seen),
        .idle_now   (idle_now),
        .late_now   (late_now),
        .t4_now     (t4_now),
        .t4_clear   (t4_clear),
        .grant_fire (grant_fire),
        .floated    (bus_floated),
        .line_q     (line_q)
    );

    assign holder = line_q;

endmodule

// File: rtl/rg_arbiter_checks.sv
// Module: protocol checker for bus_yield_arbiter, attached by bind.
// Assumes masters release only the line they were granted on.
module rg_arbiter_checks #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] rg_in,
    input logic [NUM_LINES-1:0] rg_oe,
    input logic [2:0]           phase,
    input logic                 lock_active,
    input logic                 split_first,
    input logic                 inta_first,
    input logic                 bus_floated,
    input logic [LINE_W-1:0]    holder
);

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rg_oe));

    p_grant_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |=> !(|rg_oe));

    // R8: a grant only follows an IDLE (0) or T4 (5) clock.
    p_grant_after_legal_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |-> ($past(phase) == 3'd0 || $past(phase) == 3'd5));

    p_float_follows_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_oe) |=> bus_floated);

    p_float_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_floated) |-> $past(|rg_oe));

    p_release_drops_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_floated && !rg_in[holder]) |=> !bus_floated);

    p_float_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_floated && rg_in[holder]) |=> bus_floated);

    p_dead_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_floated) |=> !(|rg_oe));

    p_qualifier_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5 && (lock_active || split_first || inta_first) && !bus_floated)
        |=> !(|rg_oe));

    p_holder_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_floated && $past(bus_floated)) |-> $stable(holder));

endmodule

bind bus_yield_arbiter rg_arbiter_checks #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
) u_rg_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .rg_in       (rg_in),
    .rg_oe       (rg_oe),
    .phase       (phase),
    .lock_active (lock_active),
    .split_first (split_first),
    .inta_first  (inta_first),
    .bus_floated (bus_floated),
    .holder      (holder)
);

// File: tb/bus_yield_arbiter_bench.sv
// Bench: behavioural reference model compared against the outputs on every clock.
module bus_yield_arbiter_bench;

    localparam int PH_IDLE = 0, PH_T1 = 1, PH_T2 = 2, PH_T3 = 3, PH_TW = 4, PH_T4 = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rg_in = 2'b11;
    logic [1:0] rg_out, rg_oe;
    logic [2:0] phase = 3'd0;
    logic       lock_active = 1'b0, split_first = 1'b0, inta_first = 1'b0;
    logic       bus_floated;
    logic [0:0] holder;

    int checks = 0;
    int errors = 0;
    string tag = "R1 reset";

    // Reference model state: 0 own, 1 waiting, 2 granting, 3 floated, 4 dead.
    int m_st = 0;
    int m_line = 0;
    bit m_early = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bus_yield_arbiter u_bus_yield_arbiter (
        .clk (clk), .rst_n (rst_n), .rg_in (rg_in), .rg_out (rg_out), .rg_oe (rg_oe),
        .phase (phase), .lock_active (lock_active), .split_first (split_first),
        .inta_first (inta_first), .bus_floated (bus_floated), .holder (holder)
    );

    task automatic compare();
        logic [1:0] exp_oe;
        logic       exp_fl;
        exp_oe = (m_st == 2) ? (2'b01 << m_line) : 2'b00;
        exp_fl = (m_st == 3);
        checks++;
        if (rg_oe !== exp_oe || (rg_out & rg_oe) !== 2'b00) begin
            errors++;
            $display("FAIL [%s] R2 grant lines oe actual %b expected %b (out %b)", tag, rg_oe, exp_oe, rg_out);
        end
        checks++;
        if (bus_floated !== exp_fl) begin
            errors++;
            $display("FAIL [%s] R4 floated actual %b expected %b", tag, bus_floated, exp_fl);
        end
        if (exp_fl) begin
            checks++;
            if (holder !== 1'(m_line)) begin
                errors++;
                $display("FAIL [%s] R4 holder actual %0d expected %0d", tag, holder, m_line);
            end
        end
    endtask

    // One clock: check outputs, apply inputs, advance the model.
    task automatic step(input bit rst, input int ph, input bit lo0, input bit lo1,
                        input bit lk, input bit sp, input bit ia);
        @(negedge clk);
        compare();
        rst_n = ~rst;
        phase = 3'(ph);
        rg_in = {~lo1, ~lo0};
        lock_active = lk; split_first = sp; inta_first = ia;
        @(posedge clk);
        if (rst) begin
            m_st = 0;
            m_line = 0;
            m_early = 0;
        end else begin
            case (m_st)
                0: if (lo0 || lo1) begin
                       m_line = lo0 ? 0 : 1;
                       if (ph == PH_IDLE) m_st = 2;
                       else begin
                           m_st = 1;
                           m_early = !(ph == PH_T3 || ph == PH_TW);
                       end
                   end
                1: if (ph == PH_IDLE) m_st = 2;
                   else if (ph == PH_T4) begin
                       if (m_early && !lk && !sp && !ia) m_st = 2;
                       else m_early = 1;
                   end
                2: m_st = 3;
                3: if ((m_line == 0) ? lo0 : lo1) m_st = 4;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, PH_IDLE, 0, 0, 0, 0, 0);
    endtask

    // One bus cycle T1,T2,T3,[TW],T4 with an optional request at phase rph.
    task automatic bus_cycle(input int rph, input int ln, input bit tw,
                             input bit lk, input bit sp, input bit ia);
        int seq[5] = '{PH_T1, PH_T2, PH_T3, PH_TW, PH_T4};
        for (int i = 0; i < 5; i++) begin
            if (seq[i] == PH_TW && !tw) continue;
            step(0, seq[i], (seq[i] == rph && ln == 0), (seq[i] == rph && ln == 1),
                 lk, sp, ia);
        end
    endtask

    task automatic release_line(input int ln);
        step(0, PH_IDLE, ln == 0, ln == 1, 0, 0, 0);
    endtask

    initial begin : watchdog
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1: lows during reset must not start an exchange.
        tag = "R1 reset";
        step(1, PH_IDLE, 1, 1, 0, 0, 0);
        step(1, PH_IDLE, 1, 0, 0, 0, 0);
        step(1, PH_IDLE, 0, 1, 0, 0, 0);
        idle(3);

        // R3: idle request on line 1, grant next clock; R4/R5 float and release.
        tag = "R3 idle request";
        step(0, PH_IDLE, 0, 1, 0, 0, 0);
        idle(4);
        tag = "R5 release";
        release_line(1);
        idle(3);

        // R7: both request together, line 0 wins.
        tag = "R7 priority";
        step(0, PH_IDLE, 1, 1, 0, 0, 0);
        idle(2);
        release_line(0);
        idle(3);

        // R8: request at T2 is granted after this cycle's T4.
        tag = "R8 early arrival";
        bus_cycle(PH_T2, 0, 0, 0, 0, 0);
        step(0, PH_T1, 0, 0, 0, 0, 0);
        idle(2);
        release_line(0);
        idle(3);

        // R8: request at T3 waits for the next cycle's T4 (with wait state).
        tag = "R8 late arrival";
        bus_cycle(PH_T3, 1, 1, 0, 0, 0);
        bus_cycle(0, 0, 0, 0, 0, 0);
        idle(2);
        release_line(1);
        idle(3);

        // R9: lock, split and interrupt-acknowledge flags each block a T4.
        tag = "R9 qualifiers";
        bus_cycle(PH_T1, 0, 0, 1, 0, 0);
        bus_cycle(0, 0, 1, 0, 1, 0);
        bus_cycle(0, 0, 0, 0, 0, 1);
        bus_cycle(0, 0, 0, 0, 0, 0);
        idle(2);
        release_line(0);
        idle(3);

        // R11: noise on the pending line while waiting does not change timing.
        tag = "R11 noise while waiting";
        bus_cycle(PH_T1, 1, 0, 1, 0, 0);
        step(0, PH_T1, 0, 1, 0, 0, 0);
        step(0, PH_T2, 0, 0, 0, 0, 0);
        step(0, PH_T3, 0, 1, 0, 0, 0);
        step(0, PH_T4, 0, 0, 0, 0, 0);
        idle(2);
        release_line(1);
        idle(3);

        // R10: the other line is ignored while line 0 holds the bus.
        tag = "R10 exclusion";
        step(0, PH_IDLE, 1, 0, 0, 0, 0);
        step(0, PH_IDLE, 0, 1, 0, 0, 0);
        step(0, PH_IDLE, 0, 1, 0, 0, 0);
        idle(1);
        release_line(0);
        idle(3);

        // R6: request in the dead clock is ignored, the next one accepted.
        tag = "R6 dead clock";
        step(0, PH_IDLE, 0, 1, 0, 0, 0);
        idle(1);
        release_line(1);
        step(0, PH_IDLE, 1, 0, 0, 0, 0);
        idle(2);
        step(0, PH_IDLE, 1, 0, 0, 0, 0);
        idle(2);
        release_line(0);
        idle(3);

        // R2: idle grant inside a running bus stream starts from an IDLE clock.
        tag = "R2 grant after idle gap";
        bus_cycle(PH_T3, 0, 0, 0, 0, 0);
        step(0, PH_IDLE, 0, 0, 0, 0, 0);
        idle(2);
        release_line(0);
        idle(3);

        @(negedge clk);
        compare();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule